// File: doc/BRIEF.md
# Shifted Pseudo-Random Sequence Pair Generator

This block produces two pseudo-random binary streams at the symbol rate for a correlation measurement. The main stream is a maximum-length sequence of N = 2^L − 1 symbols; logic 1 stands for +1 and logic 0 for −1. The companion stream carries the same sequence rotated by a start offset. The offset is one symbol in the first period and grows by one after every completed period. Over a whole run the companion stream therefore emits, row by row, every rotation of the sequence, which is the full N×N circulant matrix. No table is stored.

Three loadable Galois shift registers share one clock. The main register makes the plain stream and flags each completed period; that flag is the sample-ready strobe. A slow register steps once per period and supplies the start state of the next rotation. A third register produces the rotated stream and reloads from the slow register at every period boundary. Each period lasts N + 1 clocks, because the last symbol of both streams is held for one extra clock while sample-ready is high. After N periods the end flag rises and all outputs freeze until reset. The register length is picked at reset from five supported orders.

Top module: `mls_circ_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `sample_ready` and `xc_end` are 0 and `m_o` is 1 (the main register starts at state 1 and emits its least significant bit).
- R2: Within each period, `m_o` emits N = 2^L − 1 symbols, of which exactly 2^(L−1) are 1, and every period repeats the same N symbols.
- R3: `sample_ready` is high for exactly one clock, in the (N+1)-th clock of each period, counting the first clock after reset as clock 1.
- R4: In the clock where `sample_ready` is high, `m_o` and `mi_o` keep the values they had in the clock before.
- R5: In the first period, `mi_o` at symbol position j equals `m_o` at position j+1 (indices modulo N): it starts one symbol ahead.
- R6: In period p (counting from 1), `mi_o` at position j equals main symbol (j + p) mod N, so the offset grows by one in each period.
- R7: `xc_end` first rises in clock N·(N+1)+1 after reset, which is right after the N-th `sample_ready` pulse, and it stays high until reset.
- R8: Once `xc_end` is high, `m_o` and `mi_o` do not change and `sample_ready` stays 0.
- R9: `order_sel` codes 0, 1, 2, 3 and 4 select L = 5, 8, 10, 12 and 14. Codes 5 to 7 select L = 5.
- R10: `order_sel` is taken only while `rst` is high. Changing it during a run leaves the period length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock |
| rst | input | 1 | Synchronous active-high reset, latches the order |
| order_sel | input | SEL_W | Order code, sampled during reset |
| m_o | output | 1 | Main sequence symbol |
| mi_o | output | 1 | Rotated sequence symbol |
| sample_ready | output | 1 | One-clock strobe at each period end |
| xc_end | output | 1 | Sticky end-of-run flag |

## Verification
Full runs at orders 5 and 8 record every clock. They are checked against the first recorded period to confirm the rotation offset in each period, the held symbol and the exact strobe and end timing. This separates a wrong offset step from a wrong hold or a late end flag. Shorter runs at orders 10, 12 and 14, and with an out-of-range code, check only the period length and the balance of ones, which separates the tap masks and the order decode. One run changes the order code after reset to show that the period length stays fixed.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
   localparam int SG_STATE_W = 14;
   localparam int SG_SEL_W   = 3;

   typedef logic [SG_STATE_W-1:0] sg_state_t;
   typedef logic [SG_SEL_W-1:0]   sg_sel_t;

   typedef struct packed {
      sg_state_t mask;
      sg_state_t last_idx;
   } sg_order_t;

   function automatic int unsigned sg_order_bits(sg_sel_t code);
      case (code)
         3'd1:    return 8;
         3'd2:    return 10;
         3'd3:    return 12;
         3'd4:    return 14;
         default: return 5;
      endcase
   endfunction

   function automatic sg_state_t sg_next(sg_state_t s, sg_state_t mask);
      return (s >> 1) ^ (s[0] ? mask : '0);
   endfunction
endpackage

// File: rtl/seq_order_decode.sv
module seq_order_decode
   import seqgen_pkg::*;
(
   input  sg_sel_t   code,
   output sg_order_t ord
);
   sg_state_t taps;
   int unsigned len_bits;

   always_comb begin
      len_bits = sg_order_bits(code);
      case (len_bits)
         8:       taps = sg_state_t'(14'h00B8);
         10:      taps = sg_state_t'(14'h0240);
         12:      taps = sg_state_t'(14'h0829);
         14:      taps = sg_state_t'(14'h2015);
         default: taps = sg_state_t'(14'h0014);
      endcase
      ord.mask     = taps;
      ord.last_idx = sg_state_t'((1 << len_bits) - 2);
   end
endmodule

// File: rtl/seq_lfsr_cell.sv
module seq_lfsr_cell
   import seqgen_pkg::*;
(
   input  logic      clk,
   input  logic      load,
   input  logic      step_en,
   input  sg_state_t init,
   input  sg_state_t mask,
   input  sg_state_t last_idx,
   output sg_state_t state_o,
   output sg_state_t nxt_o,
   output logic      done_o
);
   sg_state_t state_q, idx_q;
   logic      done_q;

   assign nxt_o   = sg_next(state_q, mask);
   assign state_o = state_q;
   assign done_o  = done_q;

   always_ff @(posedge clk) begin
      if (load) begin
         state_q <= init;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (step_en) begin
            if (done_q) begin
               state_q <= nxt_o;
            end else if (idx_q == last_idx) begin
               done_q <= 1'b1;
               idx_q  <= '0;
            end else begin
               state_q <= nxt_o;
               idx_q   <= idx_q + 1'b1;
            end
         end
      end
   end

   // R2: a maximal register never reaches the all-zero lock state
   assert_state_live_R2: assert property (@(posedge clk) disable iff (load)
      state_q != '0);
   // R2: the symbol index stays inside one period
   assert_idx_range_R2: assert property (@(posedge clk) disable iff (load)
      idx_q <= last_idx);
   // R3: the completion flag lasts a single clock
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (load)
      done_q |=> !done_q);
endmodule

// File: rtl/mls_circ_seq.sv
module mls_circ_seq
   import seqgen_pkg::*;
#(
   parameter int STATE_W = 14,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] order_sel,
   output logic             m_o,
   output logic             mi_o,
   output logic             sample_ready,
   output logic             xc_end
);
   generate
      if (STATE_W != SG_STATE_W) begin : g_bad_width
         $error("STATE_W must equal the package state width");
      end
      if (SEL_W != SG_SEL_W) begin : g_bad_sel
         $error("SEL_W must equal the package select width");
      end
   endgenerate

   sg_sel_t   order_q, code_eff;
   sg_order_t ord;
   sg_state_t seed0, seed1;
   sg_state_t main_state, main_nxt, stp_state, stp_nxt, shf_state, shf_nxt;
   logic      main_done, stp_done, shf_done;
   logic      end_q, run, shf_load;

   always_ff @(posedge clk) begin
      if (rst) order_q <= sg_sel_t'(order_sel);
   end

   assign code_eff = rst ? sg_sel_t'(order_sel) : order_q;

   seq_order_decode u_dec (.code(code_eff), .ord(ord));

   assign seed0    = sg_state_t'(1);
   assign seed1    = sg_next(seed0, ord.mask);
   assign run      = !xc_end;
   assign shf_load = rst | (main_done & run);

   seq_lfsr_cell u_main (
      .clk(clk), .load(rst), .step_en(run), .init(seed0),
      .mask(ord.mask), .last_idx(ord.last_idx),
      .state_o(main_state), .nxt_o(main_nxt), .done_o(main_done));

   seq_lfsr_cell u_step (
      .clk(clk), .load(rst), .step_en(main_done & run), .init(seed1),
      .mask(ord.mask), .last_idx(ord.last_idx),
      .state_o(stp_state), .nxt_o(stp_nxt), .done_o(stp_done));

   seq_lfsr_cell u_shift (
      .clk(clk), .load(shf_load), .step_en(run),
      .init(rst ? seed1 : stp_nxt),
      .mask(ord.mask), .last_idx(ord.last_idx),
      .state_o(shf_state), .nxt_o(shf_nxt), .done_o(shf_done));

   always_ff @(posedge clk) begin
      if (rst)           end_q <= 1'b0;
      else if (stp_done) end_q <= 1'b1;
   end

   assign xc_end       = stp_done | end_q;
   assign sample_ready = main_done;
   assign m_o          = main_state[0];
   assign mi_o         = shf_state[0];

   assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      sample_ready |=> !sample_ready);
   assert_hold_symbols_R4: assert property (@(posedge clk) disable iff (rst)
      sample_ready |-> (m_o == $past(m_o) && mi_o == $past(mi_o)));
   assert_pair_aligned_R5: assert property (@(posedge clk) disable iff (rst)
      sample_ready |-> shf_done);
   assert_end_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      xc_end |=> xc_end);
   assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
      xc_end |=> ($stable(m_o) && $stable(mi_o) && !sample_ready));
   assert_order_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(order_q));
endmodule

// File: tb/sim_mls_circ_seq.sv
`timescale 1ns/1ps
module sim_mls_circ_seq;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] order_sel = 3'd0;
   logic       m_o, mi_o, sample_ready, xc_end;
   int total = 0;
   int bad   = 0;
   logic om  [0:65535];
   logic omi [0:65535];
   logic osr [0:65535];
   logic oxe [0:65535];

   always #2 clk = ~clk;

   mls_circ_seq u0 (.clk(clk), .rst(rst), .order_sel(order_sel),
      .m_o(m_o), .mi_o(mi_o), .sample_ready(sample_ready), .xc_end(xc_end));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] code);
      @(negedge clk);
      rst = 1'b1;
      order_sel = code;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #0.5;
   endtask

   task automatic next_cycle();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk(sample_ready == 0 && xc_end == 0, "R1 in reset", sample_ready + 2*xc_end, 0);
      do_reset(3'd0);
      chk(sample_ready == 0 && xc_end == 0, "R1 flags after reset", sample_ready + 2*xc_end, 0);
      chk(m_o == 1'b1, "R1 first symbol", m_o, 1);
   endtask

   task automatic t_full(input logic [2:0] code, input int L);
      int n = (1 << L) - 1;
      int cyc = n * (n + 1);
      int e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0, e8 = 0, ones = 0;
      logic lm, lmi;
      do_reset(code);
      for (int c = 1; c <= cyc + 1; c++) begin
         if (c > 1) next_cycle();
         om[c-1] = m_o; omi[c-1] = mi_o; osr[c-1] = sample_ready; oxe[c-1] = xc_end;
      end
      for (int k = 0; k < n; k++) ones += om[k];
      chk(ones == (1 << (L-1)), "R2 ones per period", ones, 1 << (L-1));
      for (int c = 1; c <= cyc; c++) begin
         int p = (c - 1) / (n + 1) + 1;
         int j = (c - 1) % (n + 1) + 1;
         int pos = (j <= n) ? j - 1 : n - 1;
         logic em  = om[pos];
         logic emi = om[(pos + p) % n];
         if (om[c-1] != em) e2++;
         if (osr[c-1] != (j == n + 1)) e3++;
         if (j == n + 1 && (om[c-1] != om[c-2] || omi[c-1] != omi[c-2])) e4++;
         if (p == 1 && omi[c-1] != emi) e5++;
         if (p > 1 && omi[c-1] != emi) e6++;
         if (oxe[c-1] != 1'b0) e7++;
      end
      chk(e2 == 0, "R2 period repeat", e2, 0);
      chk(e3 == 0, "R3 strobe timing", e3, 0);
      chk(e4 == 0, "R4 hold on strobe", e4, 0);
      chk(e5 == 0, "R5 first offset", e5, 0);
      chk(e6 == 0, "R6 offset growth", e6, 0);
      chk(e7 == 0 && oxe[cyc] == 1'b1, "R7 end timing", e7, 0);
      lm = m_o; lmi = mi_o;
      for (int k = 0; k < 6; k++) begin
         next_cycle();
         if (m_o != lm || mi_o != lmi || sample_ready || !xc_end) e8++;
      end
      chk(e8 == 0, "R8 frozen after end", e8, 0);
   endtask

   task automatic t_len(input logic [2:0] code, input int L, input string req);
      int n = (1 << L) - 1;
      int first = 0, ones = 0;
      do_reset(code);
      for (int c = 1; c <= n + 1; c++) begin
         if (c > 1) next_cycle();
         if (c <= n) ones += m_o;
         if (sample_ready && first == 0) first = c;
      end
      chk(first == n + 1, req, first, n + 1);
      chk(ones == (1 << (L-1)), "R2 balance", ones, 1 << (L-1));
   endtask

   task automatic t_sel_change();
      int first = 0;
      do_reset(3'd0);
      for (int c = 1; c <= 40; c++) begin
         if (c > 1) next_cycle();
         if (c == 3) order_sel = 3'd1;
         if (sample_ready && first == 0) first = c;
      end
      chk(first == 32, "R10 select ignored in run", first, 32);
      order_sel = 3'd0;
   endtask

   initial begin
      #(190000 * 4);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_full(3'd0, 5);
      t_full(3'd1, 8);
      t_len(3'd2, 10, "R9 code 2");
      t_len(3'd3, 12, "R9 code 3");
      t_len(3'd4, 14, "R9 code 4");
      t_len(3'd6, 5, "R9 code 6");
      t_sel_change();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule